// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. Pages are 4 KB, so the low 12 address bits pass through untouched. The upper 20 bits split into two 10-bit indices. The top index selects a 4-byte entry in a root table whose location comes from a base input. When that entry is valid, it names a second table, and the middle index selects an entry there. A valid second entry supplies the physical frame.

The walker owns one memory read port. Requests go out over a ready/valid handshake and responses come back as a valid-qualified data word, with never more than one read in flight. An invalid root entry ends the walk after a single read, so an unmapped 4 MB region needs no second table. Each walk ends with a one-cycle result: either a physical address, or a fault that says which level found the invalid entry. A new request is taken only while the walker is idle.

Top module: `two_level_walker`

## Requirements
- R1: After reset, busy, res_valid and mem_req_valid are low and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is high only while idle. busy is high from the cycle after acceptance until the result cycle, and is low in the result cycle. req_valid asserted while busy has no effect on the walk in progress.
- R3: The first read address is {root_base[31:12], 12'h000} + 4 * vaddr[31:22]. root_base and vaddr are sampled in the acceptance cycle only.
- R4: An entry is valid when bit 0 is 1. Bits 31:12 of an entry hold the frame number, or the base of the next table.
- R5: The second read address is {first_entry[31:12], 12'h000} + 4 * vaddr[21:12].
- R6: When both entries are valid, the result has res_fault=0, res_level=0 and res_paddr = {second_entry[31:12], vaddr[11:0]}.
- R7: An invalid first entry gives exactly one read and a result with res_fault=1 and res_level=1.
- R8: An invalid second entry gives exactly two reads and a result with res_fault=1 and res_level=2.
- R9: mem_req_valid stays high with a stable mem_req_addr until mem_req_ready is seen. No new read is issued while a response is still outstanding.
- R10: res_valid is high for exactly one cycle. In the following cycle req_ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Root table address (upper 20 bits used) |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_level | output | 2 | 0 on success, else the level (1 or 2) of the invalid entry |
| res_paddr | output | 32 | Translated physical address, 0 on fault |

## Verification
Two events can fall in the same cycle: presenting a finished result, and seeing a new request that has been held waiting. The bench holds req_valid high with a second address for the whole first walk. It then judges that the second request is taken only after the result strobe. It does this by comparing, in order, each result and the address of every read against a model of the table walk. Memory stalls and response delays come from a pseudo-random sequence, so the read request is also seen waiting on mem_req_ready.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_WT1  = 3'd2,
    ST_RD2  = 3'd3,
    ST_WT2  = 3'd4,
    ST_DONE = 3'd5
  } walk_state_e;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_ONE  = 2'd1;
  localparam logic [1:0] LVL_TWO  = 2'd2;

endpackage

// File: rtl/tlw_entry_addr.sv
module tlw_entry_addr #(
  parameter int PA_W     = 32,
  parameter int OFF_W    = 12,
  parameter int IDX_W    = 10,
  parameter int ENT_LOG2 = 2
) (
  input  logic [PA_W-OFF_W-1:0] base_frame,
  input  logic [IDX_W-1:0]      index,
  output logic [PA_W-1:0]       entry_addr
);

  localparam int SCALED_W = IDX_W + ENT_LOG2;

  logic [SCALED_W-1:0] scaled;
  logic [PA_W-1:0]     table_start;

  // The index is scaled to a byte offset. Entries are 2**ENT_LOG2 bytes wide.
  assign scaled      = {index, {ENT_LOG2{1'b0}}};
  assign table_start = {base_frame, {OFF_W{1'b0}}};
  assign entry_addr  = table_start + PA_W'(scaled);

endmodule

// File: rtl/tlw_ctrl.sv
module tlw_ctrl
  import tlw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        pte_ok,
  output walk_state_e state_q,
  output logic        accept,
  output logic        l1_hit,
  output logic        l1_miss,
  output logic        l2_hit,
  output logic        l2_miss,
  output logic        busy_q,
  output logic        req_ready,
  output logic        mem_req_valid,
  output logic        res_valid
);

  walk_state_e state_d;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    l1_hit  = 1'b0;
    l1_miss = 1'b0;
    l2_hit  = 1'b0;
    l2_miss = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        accept  = 1'b1;
        state_d = ST_RD1;
      end
      ST_RD1: if (mem_req_ready) state_d = ST_WT1;
      ST_WT1: if (mem_rsp_valid) begin
        if (pte_ok) begin
          l1_hit  = 1'b1;
          state_d = ST_RD2;
        end else begin
          l1_miss = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_RD2: if (mem_req_ready) state_d = ST_WT2;
      ST_WT2: if (mem_rsp_valid) begin
        l2_hit  = pte_ok;
        l2_miss = !pte_ok;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept)                busy_q <= 1'b1;
      else if (state_d == ST_DONE) busy_q <= 1'b0;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign res_valid     = (state_q == ST_DONE);

  // R2: no acceptance while a walk is in progress
  a_r2_busy_blocks_accept: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !req_ready);

  // R7: an invalid root entry ends the walk straight away
  a_r7_l1_fault_ends: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WT1 && mem_rsp_valid && !pte_ok) |=> (state_q == ST_DONE));

  // R10: one-cycle result strobe, then idle
  a_r10_result_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (!res_valid && req_ready));

endmodule

// File: rtl/tlw_datapath.sv
module tlw_datapath
  import tlw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int OFF_W    = 12,
  parameter int IDX_W    = 10,
  parameter int ENT_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             l1_hit,
  input  logic             l1_miss,
  input  logic             l2_hit,
  input  logic             l2_miss,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  root_base,
  input  logic [PTE_W-1:0] rsp_data,
  output logic [PA_W-1:0]  mem_addr,
  output logic             res_fault,
  output logic [1:0]       res_level,
  output logic [PA_W-1:0]  res_paddr
);

  localparam int FRAME_W = PA_W - OFF_W;
  localparam int HELD_W  = OFF_W + IDX_W;

  logic [HELD_W-1:0]  va_q;
  logic [FRAME_W-1:0] rsp_frame;
  logic [PA_W-1:0]    l1_addr;
  logic [PA_W-1:0]    l2_addr;
  logic               unused_bits;

  assign rsp_frame   = rsp_data[PTE_W-1 -: FRAME_W];
  assign unused_bits = ^{root_base[OFF_W-1:0], rsp_data[PTE_W-FRAME_W-1:0]};

  tlw_entry_addr #(
    .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)
  ) u_root_addr (
    .base_frame (root_base[PA_W-1:OFF_W]),
    .index      (req_vaddr[VA_W-1 -: IDX_W]),
    .entry_addr (l1_addr)
  );

  tlw_entry_addr #(
    .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)
  ) u_leaf_addr (
    .base_frame (rsp_frame),
    .index      (va_q[HELD_W-1 -: IDX_W]),
    .entry_addr (l2_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q      <= '0;
      mem_addr  <= '0;
      res_fault <= 1'b0;
      res_level <= LVL_NONE;
      res_paddr <= '0;
    end else begin
      if (accept) begin
        va_q     <= req_vaddr[HELD_W-1:0];
        mem_addr <= l1_addr;
      end
      if (l1_hit) mem_addr <= l2_addr;
      if (l1_miss) begin
        res_fault <= 1'b1;
        res_level <= LVL_ONE;
        res_paddr <= '0;
      end
      if (l2_miss) begin
        res_fault <= 1'b1;
        res_level <= LVL_TWO;
        res_paddr <= '0;
      end
      if (l2_hit) begin
        res_fault <= 1'b0;
        res_level <= LVL_NONE;
        res_paddr <= {rsp_frame, va_q[OFF_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
  import tlw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int OFF_W    = 12,
  parameter int IDX_W    = 10,
  parameter int ENT_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  root_base,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic             res_fault,
  output logic [1:0]       res_level,
  output logic [PA_W-1:0]  res_paddr
);

  walk_state_e state_q;
  logic accept, l1_hit, l1_miss, l2_hit, l2_miss;
  logic pte_ok;

  // Bit 0 of an entry is its valid flag.
  assign pte_ok = mem_rsp_data[0];

  tlw_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_ok        (pte_ok),
    .state_q       (state_q),
    .accept        (accept),
    .l1_hit        (l1_hit),
    .l1_miss       (l1_miss),
    .l2_hit        (l2_hit),
    .l2_miss       (l2_miss),
    .busy_q        (busy),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .res_valid     (res_valid)
  );

  tlw_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W),
    .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .l1_hit    (l1_hit),
    .l1_miss   (l1_miss),
    .l2_hit    (l2_hit),
    .l2_miss   (l2_miss),
    .req_vaddr (req_vaddr),
    .root_base (root_base),
    .rsp_data  (mem_rsp_data),
    .mem_addr  (mem_req_addr),
    .res_fault (res_fault),
    .res_level (res_level),
    .res_paddr (res_paddr)
  );

  // R9: a waiting read request holds its address
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9: no second read while a response is outstanding
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R6: a successful result carries level 0
  a_r6_success_level: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fault) |-> (res_level == LVL_NONE));

  // R8: a fault names level 1 or level 2
  a_r8_fault_level: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (res_level == LVL_ONE || res_level == LVL_TWO));

endmodule

// File: tb/sim_two_level_walker.sv
`timescale 1ns/1ps
module sim_two_level_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_base = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_fault;
  logic [1:0]  res_level;
  logic [31:0] res_paddr;

  always #4 clk = ~clk;

  two_level_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_base(root_base), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_level(res_level), .res_paddr(res_paddr)
  );

  typedef struct packed {
    logic        fault;
    logic [1:0]  level;
    logic [31:0] paddr;
    logic [1:0]  reads;
    logic [31:0] a1;
    logic [31:0] a2;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] obs_addr [2];
  int          obs_n = 0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;
  logic [7:0]  lf = 8'hA5;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic [31:0] root);
    exp_t e;
    logic [31:0] w1, w2;
    e = '0;
    e.a1 = {root[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
    w1 = rd(e.a1);
    if (!w1[0]) begin
      e.fault = 1'b1; e.level = 2'd1; e.reads = 2'd1;
      return e;
    end
    e.a2 = {w1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    w2 = rd(e.a2);
    e.reads = 2'd2;
    if (!w2[0]) begin
      e.fault = 1'b1; e.level = 2'd2;
    end else begin
      e.paddr = {w2[31:12], va[11:0]};
    end
    return e;
  endfunction

  task automatic wait_ready();
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
  endtask

  task automatic walk(input logic [31:0] va);
    sb.push_back(model(va, root_base));
    wait_ready();
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "busy after accept", {31'h0, busy}, 32'h1);
    chk("R2", "ready after accept", {31'h0, req_ready}, 32'h0);
  endtask

  // second request held high during the first walk
  task automatic walk_pair(input logic [31:0] va, input logic [31:0] vb);
    sb.push_back(model(va, root_base));
    sb.push_back(model(vb, root_base));
    wait_ready();
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = vb;
    wait_ready();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory model: random stalls and response delays
  initial begin
    logic        hold_pend;
    logic [31:0] hold_addr, a;
    hold_pend = 1'b0;
    forever begin
      @(negedge clk);
      if (hold_pend) begin
        chk("R9", "request held", {31'h0, mem_req_valid}, 32'h1);
        chk("R9", "address stable", mem_req_addr, hold_addr);
        hold_pend = 1'b0;
      end
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_req_ready = lf[0] | lf[1];
      if (mem_req_valid && !rst) begin
        if (!mem_req_ready) begin
          hold_pend = 1'b1;
          hold_addr = mem_req_addr;
        end else begin
          a = mem_req_addr;
          if (obs_n < 2) obs_addr[obs_n] = a;
          obs_n++;
          @(negedge clk);
          mem_req_ready = 1'b0;
          chk("R9", "no read while outstanding", {31'h0, mem_req_valid}, 32'h0);
          repeat (int'(lf[3:2]) % 3) @(negedge clk);
          mem_rsp_data  = rd(a);
          mem_rsp_valid = 1'b1;
          @(negedge clk);
          mem_rsp_valid = 1'b0;
          mem_rsp_data  = 32'hDEAD_BEE0;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (res_valid && !rst) begin
        if (sb.size() == 0) begin
          chk("R2", "unexpected result", 32'h1, 32'h0);
        end else begin
          e = sb.pop_front();
          chk("R2", "busy low in result cycle", {31'h0, busy}, 32'h0);
          chk("R3", "first read address", obs_addr[0], e.a1);
          chk(e.level == 2'd1 ? "R7" : "R8", "read count", obs_n, {30'h0, e.reads});
          if (e.reads == 2'd2) chk("R5", "second read address", obs_addr[1], e.a2);
          chk(e.fault ? (e.level == 2'd1 ? "R7" : "R8") : "R6", "fault",
              {31'h0, res_fault}, {31'h0, e.fault});
          chk(e.fault ? "R8" : "R6", "level", {30'h0, res_level}, {30'h0, e.level});
          if (!e.fault) chk("R6", "paddr", res_paddr, e.paddr);
        end
        obs_n = 0;
        @(negedge clk);
        chk("R10", "strobe one cycle", {31'h0, res_valid}, 32'h0);
        chk("R10", "ready after result", {31'h0, req_ready}, 32'h1);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R4: bit 0 = valid, bits 31:12 = frame / next table base
    mem_img[32'h0001_0000] = 32'h0002_0001;   // root A, index 0
    mem_img[32'h0001_0FFC] = 32'h0003_0001;   // root A, index 1023
    mem_img[32'h0001_0014] = 32'h0004_0000;   // root A, index 5, invalid
    mem_img[32'h0002_0000] = 32'h1234_5001;
    mem_img[32'h0002_0004] = 32'hABCD_E001;
    mem_img[32'h0002_0008] = 32'h7777_7FFE;   // invalid leaf, other bits set
    mem_img[32'h0002_0FFC] = 32'h0005_5001;
    mem_img[32'h0003_0FFC] = 32'hFFFF_F001;
    mem_img[32'h0005_0000] = 32'h0003_0001;   // root B, index 0

    root_base = 32'h0001_0ABC;                // low bits must be ignored
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy at reset", {31'h0, busy}, 32'h0);
    chk("R1", "ready at reset", {31'h0, req_ready}, 32'h1);
    chk("R1", "result at reset", {31'h0, res_valid}, 32'h0);
    chk("R1", "read at reset", {31'h0, mem_req_valid}, 32'h0);

    walk(32'h0000_0000);                      // R6 lowest address
    walk(32'h0000_1ABC);                      // R6
    walk(32'h003F_F123);                      // R6 last leaf entry
    walk(32'hFFFF_FFFF);                      // R6 last root and leaf entries
    walk(32'h0140_0000);                      // R7 invalid root entry with frame bits set
    walk(32'h0080_0000);                      // R7 absent root entry
    walk(32'h0000_2004);                      // R8 invalid leaf entry
    walk(32'h0000_3000);                      // R8 absent leaf entry

    // R3: a root change after acceptance does not affect the walk in flight
    walk(32'h0000_1010);
    root_base = 32'h0005_0000;
    walk(32'h003F_F010);                      // R3 walk through root B
    root_base = 32'h0001_0000;

    // R2/R10: second request waits through the first walk
    walk_pair(32'h0000_1555, 32'h0140_0FFF);
    walk_pair(32'h0000_2FFF, 32'hFFFF_F000);

    wait_ready();
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R2", "all results seen", sb.size(), 32'h0);
    chk("R2", "idle at end", {31'h0, busy}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule